// File: doc/BRIEF.md
# Staged Flash Write Front End

This block sits between a user access port and a flash array, and routes every write through two staging buffers. A page buffer holds one whole page of the array. A block buffer holds one block of that page. The first write to a page that is not buffered copies the page from the array into the page buffer. The block that the write addresses is then loaded into the block buffer. The write data is merged into the block buffer and into the page buffer in the same cycle, so the two buffers never disagree. A later write to another block of the same page reloads the block buffer from the page buffer and does not go back to the array.

Each access carries one, two or four bytes, and the width can change from one access to the next. Data is packed at the low end of the data bus. Two select inputs narrow the address: one points at the sector's spare page, the other pins the access to the first block of the page. Reads return page-buffer bytes when they fall inside the buffered page and array bytes otherwise. Programming the array is not part of this block, so in this block the array only provides data for reads and for page fills.

Top module: `staged_flash_writer`

## Requirements
- R1: The width code selects the access size: 00 is one byte on lanes [7:0], 01 is two bytes on lanes [15:0], and 10 and 11 are four bytes on [31:0].
- R2: The effective offset is aligned to the access size. A two-byte access ignores address bit 0 and a four-byte access ignores bits 1:0. Byte k of the access sits at the aligned offset plus k, on lane k.
- R3: Write-data lanes above the access size never change stored bytes, and read-data lanes above the access size return zero.
- R4: Address layout is [2:0] byte in block, [4:3] block, [5] page in sector and [6] sector. Array page = sector*3 + page-in-sector, or sector*3 + 2 for the spare page. Array byte L = page*32 + offset holds (37*L + 11) mod 256. A write to a page that is not buffered first copies that whole page from the array.
- R5: Only one page is buffered. A write to another page replaces it, and edits to the earlier page are no longer visible, so reads of that page return array bytes.
- R6: A write to the currently buffered block updates the block buffer and the page buffer together, and it keeps busy high for 1 cycle.
- R7: A write to another block of the buffered page reloads the block buffer from the page buffer, so earlier edits to other blocks survive. It keeps busy high for 2 cycles.
- R8: With the spare select high, the page-in-sector bit is ignored and the sector's spare page is used. With the auxiliary select high, block bits [4:3] are ignored and block 0 is used.
- R9: A request is accepted only while busy is low. A write that misses the buffered page keeps busy high for 10 cycles, starting in the cycle after acceptance. Requests presented while busy is high are ignored: they produce no read response and change no stored byte.
- R10: A read accepted while idle gives rdValid and rdData one cycle later. The data comes from the page buffer inside the buffered page and from the array elsewhere. A read never raises busy and never fills a buffer.
- R11: After reset, busy and rdValid are low and no page is buffered, so the first write takes the 10-cycle page-miss path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | 7 | Byte address |
| reqWidth | input | 2 | Access width code |
| reqData | input | 32 | Write data, packed at the low end |
| reqSpare | input | 1 | Target the sector's spare page |
| reqAux | input | 1 | Pin the access to block 0 |
| busy | output | 1 | Buffer fill or merge in progress |
| rdValid | output | 1 | Read data valid |
| rdData | output | 32 | Read data, packed at the low end |

## Verification
The case that is hardest to reach from the ports is a request that arrives in the middle of a page fill. The ports give no view of the fill, and nothing tells the bench which fill word is being copied at a given moment. The bench starts a page-miss write and then drives both a conflicting write and a read into the same page while busy is high. It checks that no read response appears. Once the fill has finished, it reads back the location of the conflicting write. The width and offset sweep walks every offset of one page with every width code. This moves the writes across all block boundaries, so the block-reload path and the same-block path are both taken many times. A reference model of the buffers, written from the requirements, predicts every read byte and every busy duration.

// File: rtl/staged_flash_pkg.sv
package staged_flash_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_BLOAD,
    ST_MERGE
  } ctrlState_t;

  // strobes from control to datapath, one per action
  typedef struct packed {
    logic capture;
    logic readOut;
    logic fillWord;
    logic fillDone;
    logic blockLoad;
    logic merge;
  } dpStrobe_t;

  // lanes used by an access of the given width code
  function automatic logic [3:0] laneMask(input logic [1:0] code);
    case (code)
      2'b00:   return 4'b0001;
      2'b01:   return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/staged_flash_array.sv
module staged_flash_array #(
  parameter int PAGE_OFF_W   = 5,
  parameter int TAG_W        = 3,
  parameter int FILL_W       = 3,
  parameter int PATTERN_MULT = 37,
  parameter int PATTERN_SEED = 11
) (
  input  logic [TAG_W-1:0]      fillPage,
  input  logic [FILL_W-1:0]     fillIdx,
  output logic [31:0]           fillData,
  input  logic [TAG_W-1:0]      peekPage,
  input  logic [PAGE_OFF_W-1:0] peekOff,
  output logic [31:0]           peekData
);

  localparam int PAGE_BYTES = 1 << PAGE_OFF_W;

  // behavioral array contents: a fixed arithmetic pattern per linear byte
  function automatic logic [7:0] patByte(input int lin);
    return 8'(lin * PATTERN_MULT + PATTERN_SEED);
  endfunction

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign fillData[8*k +: 8] =
      patByte(int'(fillPage) * PAGE_BYTES + int'(fillIdx) * 4 + k);
    assign peekData[8*k +: 8] =
      patByte(int'(peekPage) * PAGE_BYTES + int'(peekOff) + k);
  end

endmodule

// File: rtl/staged_flash_ctrl.sv
module staged_flash_ctrl
  import staged_flash_pkg::*;
#(
  parameter int FILL_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              pageHit,
  input  logic              blockHit,
  output dpStrobe_t         strobe,
  output logic [FILL_W-1:0] fillIdx,
  output logic              busy
);

  ctrlState_t state, stateNext;
  logic [FILL_W-1:0] fillCnt;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (reqWrite) begin
            strobe.capture = 1'b1;
            if (!pageHit)       stateNext = ST_FILL;
            else if (!blockHit) stateNext = ST_BLOAD;
            else                stateNext = ST_MERGE;
          end else begin
            strobe.readOut = 1'b1;
          end
        end
      end
      ST_FILL: begin
        strobe.fillWord = 1'b1;
        if (&fillCnt) begin
          strobe.fillDone = 1'b1;
          stateNext       = ST_BLOAD;
        end
      end
      ST_BLOAD: begin
        strobe.blockLoad = 1'b1;
        stateNext        = ST_MERGE;
      end
      ST_MERGE: begin
        strobe.merge = 1'b1;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      fillCnt <= '0;
    end else begin
      state <= stateNext;
      if (strobe.fillWord) fillCnt <= strobe.fillDone ? '0 : fillCnt + 1'b1;
    end
  end

  assign fillIdx = fillCnt;
  assign busy    = (state != ST_IDLE);

  // every write sequence closes with one merge cycle and returns to idle
  assert_merge_returns_R9: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_MERGE |=> state == ST_IDLE);

  // busy only ever starts from an accepted write
  assert_busy_from_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid && reqWrite));

  // a read never starts a busy period
  assert_read_not_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && !reqWrite) |=> !busy);

endmodule

// File: rtl/staged_flash_datapath.sv
module staged_flash_datapath
  import staged_flash_pkg::*;
#(
  parameter int BYTE_BITS   = 3,
  parameter int BLOCK_BITS  = 2,
  parameter int PAGE_BITS   = 1,
  parameter int SECTOR_BITS = 1,
  parameter int TAG_W       = 3,
  parameter int FILL_W      = 3,
  localparam int PAGE_OFF_W = BYTE_BITS + BLOCK_BITS,
  localparam int ADDR_W     = PAGE_OFF_W + PAGE_BITS + SECTOR_BITS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  input  logic [FILL_W-1:0]     fillIdx,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [1:0]            reqWidth,
  input  logic [31:0]           reqData,
  input  logic                  reqSpare,
  input  logic                  reqAux,
  output logic                  pageHit,
  output logic                  blockHit,
  output logic [TAG_W-1:0]      fillPage,
  input  logic [31:0]           fillData,
  output logic [TAG_W-1:0]      peekPage,
  output logic [PAGE_OFF_W-1:0] peekOff,
  input  logic [31:0]           peekData,
  output logic                  rdValid,
  output logic [31:0]           rdData
);

  localparam int BLK_BYTES        = 1 << BYTE_BITS;
  localparam int PAGE_BYTES       = 1 << PAGE_OFF_W;
  localparam int PAGES_PER_SECTOR = 1 << PAGE_BITS;

  // array page selected by an address, honouring the spare select
  function automatic logic [TAG_W-1:0] pageOf(input logic [ADDR_W-1:0] a,
                                              input logic spare);
    logic [SECTOR_BITS-1:0] sec;
    logic [PAGE_BITS-1:0]   pis;
    int                     idx;
    sec = a[ADDR_W-1 -: SECTOR_BITS];
    pis = a[PAGE_OFF_W +: PAGE_BITS];
    idx = int'(sec) * (PAGES_PER_SECTOR + 1) + (spare ? PAGES_PER_SECTOR : int'(pis));
    return TAG_W'(idx);
  endfunction

  // page offset aligned to the width, honouring the auxiliary select
  function automatic logic [PAGE_OFF_W-1:0] offOf(input logic [ADDR_W-1:0] a,
                                                  input logic [1:0] code,
                                                  input logic aux);
    logic [PAGE_OFF_W-1:0] o;
    o = a[PAGE_OFF_W-1:0];
    if (aux)          o[PAGE_OFF_W-1:BYTE_BITS] = '0;
    if (code == 2'b01) o[0] = 1'b0;
    else if (code[1])  o[1:0] = 2'b00;
    return o;
  endfunction

  // buffers
  logic [7:0] pageBuf  [PAGE_BYTES];
  logic [7:0] blockBuf [BLK_BYTES];
  logic [TAG_W-1:0]      pageTag;
  logic [BLOCK_BITS-1:0] blockTag;
  logic                  pageValid, blockValid;

  // captured write request
  logic [TAG_W-1:0]      capPage;
  logic [PAGE_OFF_W-1:0] capOff;
  logic [3:0]            capMask;
  logic [31:0]           capData;
  logic [BLOCK_BITS-1:0] capBlk;
  logic [BYTE_BITS-1:0]  capInBlk;

  // live decode of the port
  logic [TAG_W-1:0]      livePage;
  logic [PAGE_OFF_W-1:0] liveOff;
  logic [3:0]            liveMask;
  logic [BLOCK_BITS-1:0] liveBlk;
  logic [31:0]           rdNext;

  assign livePage = pageOf(reqAddr, reqSpare);
  assign liveOff  = offOf(reqAddr, reqWidth, reqAux);
  assign liveMask = laneMask(reqWidth);
  assign liveBlk  = liveOff[PAGE_OFF_W-1:BYTE_BITS];
  assign capBlk   = capOff[PAGE_OFF_W-1:BYTE_BITS];
  assign capInBlk = capOff[BYTE_BITS-1:0];

  assign pageHit  = pageValid && (pageTag == livePage);
  assign blockHit = pageHit && blockValid && (blockTag == liveBlk);

  assign fillPage = capPage;
  assign peekPage = livePage;
  assign peekOff  = liveOff;

  // read lanes: buffered page wins, unused lanes are zero
  always_comb begin
    rdNext = '0;
    for (int k = 0; k < 4; k++) begin
      if (liveMask[k]) begin
        rdNext[8*k +: 8] = pageHit ? pageBuf[liveOff + PAGE_OFF_W'(k)]
                                   : peekData[8*k +: 8];
      end
    end
  end

  // tags, flags, capture and read response
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageValid  <= 1'b0;
      blockValid <= 1'b0;
      pageTag    <= '0;
      blockTag   <= '0;
      capPage    <= '0;
      capOff     <= '0;
      capMask    <= '0;
      capData    <= '0;
      rdValid    <= 1'b0;
      rdData     <= '0;
    end else begin
      if (strobe.capture) begin
        capPage <= livePage;
        capOff  <= liveOff;
        capMask <= liveMask;
        capData <= reqData;
      end
      if (strobe.fillDone) begin
        pageValid  <= 1'b1;
        pageTag    <= capPage;
        blockValid <= 1'b0;
      end
      if (strobe.blockLoad) begin
        blockValid <= 1'b1;
        blockTag   <= capBlk;
      end
      rdValid <= strobe.readOut;
      if (strobe.readOut) rdData <= rdNext;
    end
  end

  // buffer storage, no reset: validity lives in the flags above
  always_ff @(posedge clk) begin
    if (strobe.fillWord) begin
      for (int k = 0; k < 4; k++)
        pageBuf[{fillIdx, 2'(k)}] <= fillData[8*k +: 8];
    end
    if (strobe.blockLoad) begin
      for (int j = 0; j < BLK_BYTES; j++)
        blockBuf[j] <= pageBuf[{capBlk, BYTE_BITS'(j)}];
    end
    if (strobe.merge) begin
      for (int k = 0; k < 4; k++) begin
        if (capMask[k]) begin
          blockBuf[capInBlk + BYTE_BITS'(k)] <= capData[8*k +: 8];
          pageBuf[capOff + PAGE_OFF_W'(k)]   <= capData[8*k +: 8];
        end
      end
    end
  end

  // block buffer against its slice of the page buffer
  logic blockMatches;
  always_comb begin
    blockMatches = 1'b1;
    for (int j = 0; j < BLK_BYTES; j++)
      if (blockBuf[j] != pageBuf[{blockTag, BYTE_BITS'(j)}]) blockMatches = 1'b0;
  end

  assert_block_inside_page_R6: assert property (@(posedge clk) disable iff (!rstN)
    blockValid |-> pageValid);

  assert_buffers_agree_R6: assert property (@(posedge clk) disable iff (!rstN)
    (blockValid && !strobe.fillWord) |-> blockMatches);

  assert_merge_lands_in_block_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.merge) |-> (blockValid && pageValid && blockTag == $past(capBlk)));

endmodule

// File: rtl/staged_flash_writer.sv
module staged_flash_writer
  import staged_flash_pkg::*;
#(
  parameter int BYTE_BITS    = 3,
  parameter int BLOCK_BITS   = 2,
  parameter int PAGE_BITS    = 1,
  parameter int SECTOR_BITS  = 1,
  parameter int PATTERN_MULT = 37,
  parameter int PATTERN_SEED = 11,
  localparam int PAGE_OFF_W  = BYTE_BITS + BLOCK_BITS,
  localparam int ADDR_W      = PAGE_OFF_W + PAGE_BITS + SECTOR_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqWidth,
  input  logic [31:0]       reqData,
  input  logic              reqSpare,
  input  logic              reqAux,
  output logic              busy,
  output logic              rdValid,
  output logic [31:0]       rdData
);

  localparam int ARR_PAGES = (1 << SECTOR_BITS) * ((1 << PAGE_BITS) + 1);
  localparam int TAG_W     = $clog2(ARR_PAGES);
  localparam int FILL_W    = PAGE_OFF_W - 2;

  dpStrobe_t             strobe;
  logic [FILL_W-1:0]     fillIdx;
  logic                  pageHit, blockHit;
  logic [TAG_W-1:0]      fillPage, peekPage;
  logic [PAGE_OFF_W-1:0] peekOff;
  logic [31:0]           fillData, peekData;

  staged_flash_ctrl #(.FILL_W(FILL_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .pageHit  (pageHit),
    .blockHit (blockHit),
    .strobe   (strobe),
    .fillIdx  (fillIdx),
    .busy     (busy)
  );

  staged_flash_datapath #(
    .BYTE_BITS   (BYTE_BITS),
    .BLOCK_BITS  (BLOCK_BITS),
    .PAGE_BITS   (PAGE_BITS),
    .SECTOR_BITS (SECTOR_BITS),
    .TAG_W       (TAG_W),
    .FILL_W      (FILL_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .fillIdx  (fillIdx),
    .reqAddr  (reqAddr),
    .reqWidth (reqWidth),
    .reqData  (reqData),
    .reqSpare (reqSpare),
    .reqAux   (reqAux),
    .pageHit  (pageHit),
    .blockHit (blockHit),
    .fillPage (fillPage),
    .fillData (fillData),
    .peekPage (peekPage),
    .peekOff  (peekOff),
    .peekData (peekData),
    .rdValid  (rdValid),
    .rdData   (rdData)
  );

  staged_flash_array #(
    .PAGE_OFF_W   (PAGE_OFF_W),
    .TAG_W        (TAG_W),
    .FILL_W       (FILL_W),
    .PATTERN_MULT (PATTERN_MULT),
    .PATTERN_SEED (PATTERN_SEED)
  ) u_array (
    .fillPage (fillPage),
    .fillIdx  (fillIdx),
    .fillData (fillData),
    .peekPage (peekPage),
    .peekOff  (peekOff),
    .peekData (peekData)
  );

endmodule

// File: tb/test_staged_flash_writer.sv
module test_staged_flash_writer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [6:0]  reqAddr = '0;
  logic [1:0]  reqWidth = '0;
  logic [31:0] reqData = '0;
  logic        reqSpare = 1'b0;
  logic        reqAux = 1'b0;
  logic        busy, rdValid;
  logic [31:0] rdData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  staged_flash_writer i_staged_flash_writer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWidth(reqWidth), .reqData(reqData),
    .reqSpare(reqSpare), .reqAux(reqAux), .busy(busy),
    .rdValid(rdValid), .rdData(rdData)
  );

  // reference model of the buffers
  logic [7:0] mPage [32];
  int  mTag = 0;
  bit  mPV = 1'b0, mBV = 1'b0;
  int  mBlk = 0;

  function automatic logic [7:0] pat(input int lin);
    return 8'(lin * 37 + 11);
  endfunction

  function automatic int ePage(input logic [6:0] a, input bit spare);
    return int'(a[6]) * 3 + (spare ? 2 : int'(a[5]));
  endfunction

  function automatic int eOff(input logic [6:0] a, input logic [1:0] w, input bit aux);
    int o;
    o = int'(a[4:0]);
    if (aux) o = o & 7;
    if (w == 2'b01) o = o & ~1;
    else if (w[1]) o = o & ~3;
    return o;
  endfunction

  function automatic int nBytes(input logic [1:0] w);
    return (w == 2'b00) ? 1 : (w == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic [31:0] expRead(input logic [6:0] a, input logic [1:0] w,
                                          input bit spare, input bit aux);
    logic [31:0] r;
    int pg, off;
    r = '0;
    pg = ePage(a, spare);
    off = eOff(a, w, aux);
    for (int k = 0; k < nBytes(w); k++)
      r[8*k +: 8] = (mPV && mTag == pg) ? mPage[off + k] : pat(pg * 32 + off + k);
    return r;
  endfunction

  // applies a write to the model and returns the expected busy length
  function automatic int modelWrite(input logic [6:0] a, input logic [1:0] w,
                                    input logic [31:0] d, input bit spare, input bit aux);
    int pg, off, blk, cyc;
    pg = ePage(a, spare);
    off = eOff(a, w, aux);
    blk = off / 8;
    if (!mPV || mTag != pg) begin
      cyc = 10;
      for (int i = 0; i < 32; i++) mPage[i] = pat(pg * 32 + i);
      mTag = pg; mPV = 1'b1; mBV = 1'b0;
    end else if (!mBV || mBlk != blk) cyc = 2;
    else cyc = 1;
    mBV = 1'b1; mBlk = blk;
    for (int k = 0; k < nBytes(w); k++) mPage[off + k] = d[8*k +: 8];
    return cyc;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input bit wr, input logic [6:0] a, input logic [1:0] w,
                       input logic [31:0] d, input bit spare, input bit aux);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWidth = w;
    reqData = d; reqSpare = spare; reqAux = aux;
  endtask

  // called at a negedge with busy low; returns at a negedge with busy low
  task automatic doWrite(input logic [6:0] a, input logic [1:0] w, input logic [31:0] d,
                         input bit spare, input bit aux, input string req);
    int expCyc, cnt;
    expCyc = modelWrite(a, w, d, spare, aux);
    drive(1'b1, a, w, d, spare, aux);
    @(negedge clk);
    reqValid = 1'b0;
    cnt = 0;
    while (busy && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt == expCyc, req, "busy cycles of write", 32'(cnt), 32'(expCyc));
  endtask

  task automatic doRead(input logic [6:0] a, input logic [1:0] w,
                        input bit spare, input bit aux, input string req);
    logic [31:0] e;
    e = expRead(a, w, spare, aux);
    drive(1'b0, a, w, 32'hDEAD_BEEF, spare, aux);
    @(negedge clk);
    reqValid = 1'b0;
    check(rdValid == 1'b1, req, "read valid", 32'(rdValid), 32'd1);
    check(rdData == e, req, "read data", rdData, e);
    check(busy == 1'b0, "R10", "busy after read", 32'(busy), 32'd0);
  endtask

  function automatic logic [31:0] sweepData(input int w, input int off);
    return {8'(w * 16 + off), 8'(off ^ 8'h5A), 8'(w + off * 3), 8'(off * 7 + 1)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(busy == 1'b0, "R11", "busy in reset", 32'(busy), 32'd0);
    check(rdValid == 1'b0, "R11", "rdValid in reset", 32'(rdValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R11", "busy after reset", 32'(busy), 32'd0);

    // R10: unbuffered reads of every word of every array page
    for (int sec = 0; sec < 2; sec++)
      for (int pg = 0; pg < 3; pg++)
        for (int wd = 0; wd < 8; wd++)
          doRead(7'(sec * 64 + (pg == 1 ? 32 : 0) + wd * 4), 2'b10, pg == 2, 1'b0, "R10");

    // R11/R4: first write takes the page-miss path, page then mirrors array
    doWrite(7'h0A, 2'b00, 32'hFFFF_FF3C, 1'b0, 1'b0, "R11");
    for (int i = 0; i < 32; i++) doRead(7'(i), 2'b00, 1'b0, 1'b0, "R4");

    // R1/R2/R3: every width at every offset of page sector0/page1
    for (int w = 0; w < 4; w++)
      for (int off = 0; off < 32; off++) begin
        doWrite(7'(32 + off), 2'(w), sweepData(w, off), 1'b0, 1'b0, "R9");
        doRead(7'(32 + off), 2'(w), 1'b0, 1'b0, "R1");
        doRead(7'(32 + (off & ~3)), 2'b11, 1'b0, 1'b0, "R3");
        doRead(7'(32 + off), 2'b01, 1'b0, 1'b0, "R2");
      end

    // R6/R7: same block, other block, back again
    doWrite(7'h41, 2'b00, 32'h0000_0011, 1'b0, 1'b0, "R9");
    doWrite(7'h42, 2'b00, 32'h0000_0022, 1'b0, 1'b0, "R6");
    doWrite(7'h52, 2'b01, 32'h0000_3344, 1'b0, 1'b0, "R7");
    doWrite(7'h43, 2'b00, 32'h0000_0055, 1'b0, 1'b0, "R7");
    doRead(7'h40, 2'b11, 1'b0, 1'b0, "R7");
    doRead(7'h50, 2'b10, 1'b0, 1'b0, "R6");

    // R5: moving to another page drops the edits of the first
    doWrite(7'h60, 2'b10, 32'h1234_5678, 1'b0, 1'b0, "R5");
    doRead(7'h40, 2'b10, 1'b0, 1'b0, "R5");
    doRead(7'h52, 2'b01, 1'b0, 1'b0, "R5");
    doRead(7'h60, 2'b10, 1'b0, 1'b0, "R5");

    // R8: spare select ignores the page bit, aux select ignores block bits
    doWrite(7'h3C, 2'b10, 32'hCAFE_F00D, 1'b1, 1'b0, "R8");
    doWrite(7'h1D, 2'b00, 32'h0000_00A7, 1'b1, 1'b0, "R8");
    doRead(7'h1C, 2'b10, 1'b1, 1'b0, "R8");
    doRead(7'h3C, 2'b10, 1'b1, 1'b1, "R8");
    doWrite(7'h3A, 2'b01, 32'h0000_BEEF, 1'b1, 1'b1, "R8");
    doRead(7'h02, 2'b01, 1'b1, 1'b0, "R8");
    doRead(7'h1A, 2'b01, 1'b1, 1'b0, "R8");

    // R9: requests during a page fill are ignored
    begin
      int expCyc, cnt;
      expCyc = modelWrite(7'h44, 2'b00, 32'h0000_0066, 1'b0, 1'b0);
      drive(1'b1, 7'h44, 2'b00, 32'h0000_0066, 1'b0, 1'b0);
      @(negedge clk);
      drive(1'b1, 7'h48, 2'b10, 32'hFFFF_FFFF, 1'b0, 1'b0);
      check(busy == 1'b1, "R9", "busy after accept", 32'(busy), 32'd1);
      cnt = 1;
      @(negedge clk);
      drive(1'b0, 7'h48, 2'b10, 32'h0, 1'b0, 1'b0);
      cnt++;
      @(negedge clk);
      check(rdValid == 1'b0, "R9", "read during busy", 32'(rdValid), 32'd0);
      reqValid = 1'b0;
      while (busy && cnt < 100) begin
        cnt++;
        @(negedge clk);
      end
      check(rdValid == 1'b0, "R9", "no late read", 32'(rdValid), 32'd0);
      check(cnt == expCyc, "R9", "busy cycles of fill", 32'(cnt), 32'(expCyc));
      doRead(7'h48, 2'b10, 1'b0, 1'b0, "R9");
      doRead(7'h44, 2'b10, 1'b0, 1'b0, "R9");
    end

    // R10: a read outside the buffered page returns array bytes
    doRead(7'h00, 2'b10, 1'b0, 1'b0, "R10");
    doRead(7'h7C, 2'b10, 1'b0, 1'b0, "R10");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule